// File: doc/BRIEF.md
# Reset-Pin Operation Abort Sequencer

This block sits in a flash-style memory controller next to the internally timed write engine. It watches the active-low reset pin of the memory, brought in through a two-flop synchronizer. If the pin is held low long enough while a program or erase operation is in flight, the block asks the write engine to stop. It then holds a fixed shutdown interval and flags the target of the interrupted operation as holding undefined data. For a program operation that target is one location; for an erase operation it is the whole block.

At the end of the shutdown interval the sequencer picks the next mode from the pin level at that moment. A released pin leads to read array mode. A pin that is still low leads to deep reset mode, and leaving that mode always returns to read array mode. Separate read and write recovery counters keep the read-ready and write-ready strobes low until each has expired. After an abort where the pin was released during shutdown, these counters start at the end of the shutdown interval and not at the release. A reset that arrives while the engine is idle skips the shutdown interval, and recovery then starts when the release is seen.

Top module: `abort_seq`

## Requirements
- R1: While and after `rst_ni` is low, `mode_reset_o`=1, `abort_o`=0, `inval_o`=0, `rd_ready_o`=0 and `wr_ready_o`=0.
- R2: Take E0 as the first clock edge that samples `pin_rst_ni` low. If the pin stays low for MIN_PULSE sampling edges while `busy_i`=1, `abort_o` is high after edge E(MIN_PULSE+1).
- R3: A low pulse on `pin_rst_ni` that spans only MIN_PULSE-1 sampling edges while `busy_i`=1 is ignored. `abort_o`, `inval_o` and `mode_reset_o` stay 0, and both ready outputs stay 1.
- R4: `abort_o` stays high for exactly SHUT_CYC cycles and then falls.
- R5: `inval_o` is high for one cycle, in the first cycle of `abort_o`. In that cycle `inval_blk_o`=1 for an erase (`op_erase_i`=1) and 0 for a program. `inval_addr_o` gives `op_addr_i` for a program. For an erase it gives `op_addr_i` with its low BLK_BITS bits cleared.
- R6: At the end of shutdown the mode depends on the pin. If the synchronized pin is high at the edge that ends shutdown, the block enters read array mode (`mode_reset_o`=0). Otherwise it enters deep reset mode (`mode_reset_o`=1).
- R7: If an abort ends in read array mode, `rd_ready_o` rises RD_REC cycles after the edge that ends shutdown, and `wr_ready_o` rises WR_REC cycles after it. This holds however early the pin was released.
- R8: Deep reset mode always exits to read array mode at the edge that samples the synchronized pin high. The recovery counters then start from that edge.
- R9: A reset while `busy_i`=0 raises neither `abort_o` nor `inval_o`. `mode_reset_o` is high after edge E2, and there is no shutdown interval.
- R10: `rd_ready_o` and `wr_ready_o` are 0 in every cycle in which `abort_o` or `mode_reset_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the sequencer logic |
| pin_rst_ni | input | 1 | Raw active-low reset pin, asynchronous to `clk_i` |
| busy_i | input | 1 | Write engine is running a program or erase |
| op_erase_i | input | 1 | Current operation is an erase (1) or a program (0) |
| op_addr_i | input | AW | Target address of the current operation |
| abort_o | output | 1 | Abort request to the write engine, high during shutdown |
| mode_reset_o | output | 1 | 1 = deep reset mode, 0 = read array mode |
| inval_o | output | 1 | One-cycle strobe: the reported target holds undefined data |
| inval_blk_o | output | 1 | Reported target is a whole block |
| inval_addr_o | output | AW | Address, or block base address, of the reported target |
| rd_ready_o | output | 1 | Reads may start |
| wr_ready_o | output | 1 | Writes may start |

## Verification
Two events can fall in the same cycle: the last cycle of shutdown and the edge at which the synchronized pin is first seen high. The bench provokes this by releasing the pin so that its synchronized rising edge lands exactly on the shutdown-ending edge, and again one cycle later. The first case must give read array mode with recovery counted from that edge. The second must give one cycle of deep reset mode and recovery counted from the following edge. A second coincidence is between the qualifying pulse length and the abort decision. Pulses of MIN_PULSE-1 and MIN_PULSE edges are compared cycle by cycle against a timeline that the bench derives from the requirements.

// File: rtl/abort_seq_pkg.sv
package abort_seq_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_QUAL,
    ST_SHUT,
    ST_RST,
    ST_REC
  } seq_st_e;
endpackage

// File: rtl/abort_seq_sync.sv
module abort_seq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  // reset value 0: pin treated as asserted until sampled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/abort_seq_dly.sv
module abort_seq_dly #(
  parameter int unsigned CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(CYC + 2);
  localparam logic [CW-1:0] LOAD_VAL = CW'(CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= LOAD_VAL;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  a_r7_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/abort_seq_inval.sv
module abort_seq_inval #(
  parameter int unsigned AW       = 16,
  parameter int unsigned BLK_BITS = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          commit_i,
  input  logic          erase_i,
  input  logic [AW-1:0] addr_i,
  output logic          inval_o,
  output logic          blk_o,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] BLK_MASK = ~((AW'(1) << BLK_BITS) - AW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inval_o <= 1'b0;
      blk_o   <= 1'b0;
      addr_o  <= '0;
    end else begin
      inval_o <= commit_i;
      if (commit_i) begin
        blk_o  <= erase_i;
        addr_o <= erase_i ? (addr_i & BLK_MASK) : addr_i;
      end
    end
  end
endmodule

// File: rtl/abort_seq_ctrl.sv
module abort_seq_ctrl
  import abort_seq_pkg::*;
#(
  parameter int unsigned MIN_PULSE = 4,
  parameter int unsigned SHUT_CYC  = 6
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    pin_s_i,
  input  logic    busy_i,
  input  logic    rec_done_i,
  output seq_st_e st_o,
  output logic    commit_o,
  output logic    rec_load_o
);
  localparam int unsigned MAXC = (MIN_PULSE > SHUT_CYC) ? MIN_PULSE : SHUT_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] QUAL_LAST = CW'(MIN_PULSE - 1);
  localparam logic [CW-1:0] SHUT_LAST = CW'(SHUT_CYC - 1);

  seq_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    commit_o = 1'b0;
    unique case (st_q)
      ST_RUN: if (!pin_s_i) begin
        st_d  = busy_i ? ST_QUAL : ST_RST;
        cnt_d = CW'(1);
      end
      ST_QUAL: begin
        if (pin_s_i)                 st_d = ST_RUN;   // short pulse ignored
        else if (!busy_i)            st_d = ST_RST;   // engine finished on its own
        else if (cnt_q == QUAL_LAST) begin
          st_d     = ST_SHUT;
          cnt_d    = '0;
          commit_o = 1'b1;
        end else                     cnt_d = cnt_q + 1'b1;
      end
      ST_SHUT: begin
        if (cnt_q == SHUT_LAST) st_d = pin_s_i ? ST_REC : ST_RST;
        else                    cnt_d = cnt_q + 1'b1;
      end
      ST_RST: if (pin_s_i) st_d = ST_REC;
      ST_REC: begin
        if (!pin_s_i)        st_d = ST_RST;
        else if (rec_done_i) st_d = ST_RUN;
      end
      default: st_d = ST_RST;
    endcase
  end

  assign rec_load_o = (st_d == ST_REC) && (st_q != ST_REC);
  assign st_o       = st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_RST;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  a_r2_abort_needs_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SHUT && $past(st_q) == ST_QUAL) |-> $past(busy_i) && !$past(pin_s_i));
  a_r6_mode_at_shut_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q) == ST_SHUT && st_q != ST_SHUT) |-> ((st_q == ST_RST) == !$past(pin_s_i)));
  a_r8_reset_exits_to_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q) == ST_RST && st_q != ST_RST) |-> (st_q == ST_REC));
endmodule

// File: rtl/abort_seq.sv
module abort_seq
  import abort_seq_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned BLK_BITS  = 4,
  parameter int unsigned MIN_PULSE = 4,
  parameter int unsigned SHUT_CYC  = 6,
  parameter int unsigned RD_REC    = 3,
  parameter int unsigned WR_REC    = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pin_rst_ni,
  input  logic          busy_i,
  input  logic          op_erase_i,
  input  logic [AW-1:0] op_addr_i,
  output logic          abort_o,
  output logic          mode_reset_o,
  output logic          inval_o,
  output logic          inval_blk_o,
  output logic [AW-1:0] inval_addr_o,
  output logic          rd_ready_o,
  output logic          wr_ready_o
);
  seq_st_e st;
  logic    pin_s, commit, rec_load, rd_done, wr_done;

  abort_seq_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_rst_ni), .q_o(pin_s)
  );

  abort_seq_ctrl #(.MIN_PULSE(MIN_PULSE), .SHUT_CYC(SHUT_CYC)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_s_i(pin_s), .busy_i(busy_i),
    .rec_done_i(rd_done && wr_done), .st_o(st), .commit_o(commit),
    .rec_load_o(rec_load)
  );

  abort_seq_dly #(.CYC(RD_REC)) u_rd_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(rec_load), .done_o(rd_done)
  );

  abort_seq_dly #(.CYC(WR_REC)) u_wr_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(rec_load), .done_o(wr_done)
  );

  abort_seq_inval #(.AW(AW), .BLK_BITS(BLK_BITS)) u_inval (
    .clk_i(clk_i), .rst_ni(rst_ni), .commit_i(commit), .erase_i(op_erase_i),
    .addr_i(op_addr_i), .inval_o(inval_o), .blk_o(inval_blk_o), .addr_o(inval_addr_o)
  );

  logic live;
  assign live         = (st == ST_RUN) || (st == ST_QUAL);
  assign abort_o      = (st == ST_SHUT);
  assign mode_reset_o = (st == ST_RST);
  assign rd_ready_o   = live || (st == ST_REC && rd_done);
  assign wr_ready_o   = live || (st == ST_REC && wr_done);

  a_r10_ready_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_o || mode_reset_o) |-> (!rd_ready_o && !wr_ready_o));
  a_r5_inval_with_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(abort_o) |-> inval_o);
  a_r5_inval_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_o |=> !inval_o);
  a_r4_no_inval_outside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_o |-> abort_o);
endmodule

// File: tb/sim_abort_seq.sv
module sim_abort_seq;
  localparam int CLK_P = 10;
  localparam int AW = 16, BB = 4, MP = 4, SH = 6, RR = 3, WR = 5;
  localparam int NV = 9;

  typedef struct packed {
    logic [31:0]   len;
    logic          busy;
    logic          erase;
    logic [AW-1:0] addr;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{32'd3,  1'b1, 1'b0, 16'h1234},   // one short of qualifying
    '{32'd4,  1'b1, 1'b0, 16'h1234},   // minimum qualifying pulse, program
    '{32'd4,  1'b1, 1'b1, 16'h5678},   // erase, block base 5670
    '{32'd7,  1'b1, 1'b0, 16'hABCD},
    '{32'd9,  1'b1, 1'b1, 16'h0F0F},   // release seen exactly at shutdown end
    '{32'd10, 1'b1, 1'b0, 16'h4321},   // release one cycle late
    '{32'd16, 1'b1, 1'b1, 16'hFFFF},
    '{32'd1,  1'b0, 1'b0, 16'h0000},   // idle reset, short
    '{32'd5,  1'b0, 1'b1, 16'h2222}
  };

  logic clk = 0, rst_n = 0, pin_n = 1, busy = 0, erase = 0;
  logic [AW-1:0] addr = '0;
  logic abort, mode_rst, inval, inval_blk, rd_rdy, wr_rdy;
  logic [AW-1:0] inval_addr;
  int errs = 0, checks = 0, cyc = 0;

  always #(CLK_P/2) clk = ~clk;

  abort_seq #(.AW(AW), .BLK_BITS(BB), .MIN_PULSE(MP), .SHUT_CYC(SH),
              .RD_REC(RR), .WR_REC(WR)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pin_rst_ni(pin_n), .busy_i(busy),
    .op_erase_i(erase), .op_addr_i(addr), .abort_o(abort), .mode_reset_o(mode_rst),
    .inval_o(inval), .inval_blk_o(inval_blk), .inval_addr_o(inval_addr),
    .rd_ready_o(rd_rdy), .wr_ready_o(wr_rdy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s t=%0t act=%0h exp=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic done_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      done_run();
    end
  end

  task automatic run_vec(input vec_t v);
    int  len   = int'(v.len);
    bit  ab    = v.busy && (len >= MP);
    int  es    = MP + 1 + SH;
    int  drop  = ab ? MP + 1 : 2;
    int  rs    = ab ? ((len + 2 > es) ? len + 2 : es) : len + 2;
    int  last  = (!ab && v.busy) ? len + 6 : rs + WR + 3;
    logic [AW-1:0] exp_addr = v.erase ? (v.addr & ~AW'((1 << BB) - 1)) : v.addr;
    @(negedge clk);
    busy = v.busy; erase = v.erase; addr = v.addr; pin_n = 0;
    for (int i = 0; i < last; i++) begin
      bit e_ab, e_inv, e_md, e_rd, e_wr;
      @(posedge clk); @(negedge clk);
      e_ab  = ab && i >= MP + 1 && i <= MP + SH;
      e_inv = ab && i == MP + 1;
      if (ab)          e_md = i >= es && i < rs;
      else if (!v.busy) e_md = i >= 2 && i < rs;
      else             e_md = 1'b0;
      if (!ab && v.busy) begin e_rd = 1; e_wr = 1; end
      else begin
        e_rd = (i < drop) || (i >= rs + RR);
        e_wr = (i < drop) || (i >= rs + WR);
      end
      if (ab) chk("R2_R4_abort", 32'(abort), 32'(e_ab));
      else if (v.busy) chk("R3_abort", 32'(abort), 32'(e_ab));
      else chk("R9_abort", 32'(abort), 32'(e_ab));
      chk(v.busy ? "R5_inval" : "R9_inval", 32'(inval), 32'(e_inv));
      if (e_inv) begin
        chk("R5_blk", 32'(inval_blk), 32'(v.erase));
        chk("R5_addr", 32'(inval_addr), 32'(exp_addr));
      end
      if (ab && i == es) chk("R6_mode_shut_end", 32'(mode_rst), 32'(e_md));
      else if (!v.busy)  chk("R9_mode", 32'(mode_rst), 32'(e_md));
      else               chk("R8_mode", 32'(mode_rst), 32'(e_md));
      chk((e_ab || e_md) ? "R10_rd" : "R7_rd", 32'(rd_rdy), 32'(e_rd));
      chk((e_ab || e_md) ? "R10_wr" : "R7_wr", 32'(wr_rdy), 32'(e_wr));
      if (i == len - 1) pin_n = 1;
      if (i == MP + 1 || (!ab && i == len + 2)) busy = 0;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state during logic reset
    chk("R1_mode", 32'(mode_rst), 32'd1);
    chk("R1_abort", 32'(abort), 32'd0);
    chk("R1_inval", 32'(inval), 32'd0);
    chk("R1_rd", 32'(rd_rdy), 32'd0);
    chk("R1_wr", 32'(wr_rdy), 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1_mode_after", 32'(mode_rst), 32'd1);
    chk("R1_rd_after", 32'(rd_rdy), 32'd0);
    repeat (20) @(negedge clk);
    chk("R8_read_after_por", 32'(mode_rst), 32'd0);
    chk("R7_ready_after_por", 32'(rd_rdy & wr_rdy), 32'd1);

    for (int k = 0; k < NV; k++) run_vec(VEC[k]);

    // R1: logic reset in the middle of shutdown
    @(negedge clk);
    busy = 1; pin_n = 0;
    repeat (MP + 3) @(negedge clk);
    chk("R4_in_shutdown", 32'(abort), 32'd1);
    rst_n = 0;
    #1;
    chk("R1_mid_abort", 32'(abort), 32'd0);
    chk("R1_mid_mode", 32'(mode_rst), 32'd1);
    chk("R1_mid_rd", 32'(rd_rdy), 32'd0);
    @(negedge clk);
    busy = 0; pin_n = 1; rst_n = 1;
    repeat (20) @(negedge clk);
    chk("R8_recover_again", 32'(rd_rdy & wr_rdy & ~mode_rst), 32'd1);
    done_run();
  end
endmodule